// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache for a 10-bit byte address space. It stores 128 bytes as eight blocks of four 32-bit words, arranged as four sets of two ways. A request presents a byte address. The block compares the tags of both ways of the indexed set together. On a hit it returns the stored word. On a miss it loads the whole block from a word-wide memory port, one word at a time, and then returns the requested word.

When a set is full, the way to evict is chosen with an approximate least-recently-used scheme. Every block has a use bit. The bit is set whenever the block is hit or freshly loaded. A free-running interval timer clears all use bits together. An empty way is always used before a valid one is evicted. When both use bits of a full set are equal, a fixed rule or a toggling pointer breaks the tie.

Top module: `c2w_cache`

## Requirements
- R1: The address splits as tag = addr[9:6], set index = addr[5:4], word-in-block = addr[3:2] and byte = addr[1:0]. The byte bits do not affect which word is returned, and any word of a loaded block hits.
- R2: When either way of the indexed set holds a valid block with a matching tag, resp_valid pulses for one cycle two clock edges after acceptance, with resp_hit = 1 and the stored word on resp_data.
- R3: On a miss, mem_rd_en stays high while the block's four words are read in ascending order. The addresses are {tag, index, 2'b00..2'b11, 2'b00}, and each word is taken on a cycle where mem_ack is high. After the last word, resp_valid pulses with resp_hit = 0 and the requested word.
- R4: After reset the cache holds nothing, req_ready = 1, resp_valid = 0 and mem_rd_en = 0. req_ready is low from the cycle after acceptance until the response.
- R5: A miss fills an invalid way before any valid way is evicted. Way 0 is chosen when both ways are empty.
- R6: The use bit of a block is set when it is hit and when it is loaded.
- R7: All use bits are cleared together once every CLR_PERIOD clock cycles, counted from reset release. A clear on the same edge as a hit leaves that hit block's use bit set.
- R8: In a full set, the victim is a way whose use bit is clear. When both use bits are set, way 0 is evicted.
- R9: In a full set with both use bits clear, a one-bit pointer picks the victim. The pointer starts at way 0 after reset and toggles each time it is used.
- R10: From empty, the addresses 0100111000, 1100110100, 0100111100, 0110110000, 1100111000 give miss, miss, hit, miss, hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 10 | Byte address of the request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from the cache without a refill |
| resp_data | output | 32 | Requested word |
| mem_rd_en | output | 1 | Refill read in progress |
| mem_addr | output | 10 | Byte address of the word being refilled |
| mem_ack | input | 1 | Memory returns mem_rdata this cycle |
| mem_rdata | input | 32 | Word from memory |

## Verification
The fixed reference sequence tells a correct two-way layout apart from a direct-mapped or wrongly split address. A byte-offset variant and a second word of an already loaded block show that only tag, index and word select matter. Three replacement scenarios are started from reset with a known timer phase. They separate the victim rules: both use bits set, exactly one clear, and both clear on two successive occasions. One scenario also separates a clear that lands on a hit from a clear alone. The memory model acknowledges only every other cycle, which exposes refills that ignore mem_ack or fetch words out of order.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } state_e;
endpackage

// File: rtl/c2w_data_ram.sv
module c2w_data_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // plain synchronous write and registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/c2w_use_bits.sv
module c2w_use_bits #(
  parameter int SETS   = 4,
  parameter int PERIOD = 64,
  localparam int IW    = $clog2(SETS),
  localparam int CW    = $clog2(PERIOD + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [IW-1:0]        set_idx,
  input  logic                 set_way,
  output logic [SETS-1:0][1:0] use_o
);
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      use_o <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < 2; w++) begin
          // the set term wins over the clear term on a shared edge
          use_o[s][w] <= (use_o[s][w] & ~tick) |
                         (set_en && set_idx == IW'(s) && set_way == 1'(w));
        end
      end
    end
  end

  logic [IW-1:0] chk_idx_q;
  logic          chk_way_q;
  always_ff @(posedge clk) begin
    chk_idx_q <= set_idx;
    chk_way_q <= set_way;
  end

  AST_USE_SET_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> use_o[chk_idx_q][chk_way_q]);  // R6
  AST_CLEAR_WIPES_ALL: assert property (@(posedge clk) disable iff (rst)
    (tick && !set_en) |=> (use_o == '0));      // R7
endmodule

// File: rtl/c2w_victim.sv
module c2w_victim (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] valid_i,
  input  logic [1:0] use_i,
  input  logic       take_i,
  output logic       way_o
);
  logic ptr_q;
  logic tie_clear;

  assign tie_clear = (&valid_i) && (use_i == 2'b00);

  always_comb begin
    if (!valid_i[0])          way_o = 1'b0;
    else if (!valid_i[1])     way_o = 1'b1;
    else if (use_i == 2'b01)  way_o = 1'b1;
    else if (tie_clear)       way_o = ptr_q;
    else                      way_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                       ptr_q <= 1'b0;
    else if (take_i && tie_clear)  ptr_q <= ~ptr_q;
  end

  AST_VICTIM_USE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (take_i && (&valid_i) && use_i != 2'b11) |-> !use_i[way_o]);  // R8
  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (take_i && tie_clear) |=> (ptr_q != $past(ptr_q)));           // R9
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache #(
  parameter int ADDR_W      = 10,
  parameter int WORD_W      = 32,
  parameter int SETS        = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int CLR_PERIOD  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  import c2w_pkg::*;

  localparam int BYTE_W    = $clog2(WORD_W / 8);
  localparam int BOFF_W    = $clog2(BLOCK_WORDS);
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - IDX_W - BOFF_W - BYTE_W;
  localparam int RAM_DEPTH = SETS * BLOCK_WORDS;
  localparam int RAM_AW    = IDX_W + BOFF_W;

  state_e              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [BOFF_W-1:0]   cnt_q;
  logic                vic_q;
  logic [WORD_W-1:0]   fill_word_q;
  logic [SETS-1:0][1:0] valid_q;
  logic [TAG_W-1:0]    tag_q [SETS][2];

  logic [TAG_W-1:0]    tag_f;
  logic [IDX_W-1:0]    idx_f;
  logic [BOFF_W-1:0]   boff_f;
  logic [1:0]          hit_w;
  logic [1:0][WORD_W-1:0] rd_data;
  logic [SETS-1:0][1:0] use_w;
  logic                accept;
  logic                look_hit;
  logic                look_miss;
  logic                fill_last;
  logic                vic_w;
  logic [RAM_AW-1:0]   rd_addr;
  logic [RAM_AW-1:0]   wr_addr;
  logic                unused_bits;

  assign tag_f  = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_f  = addr_q[BYTE_W+BOFF_W +: IDX_W];
  assign boff_f = addr_q[BYTE_W +: BOFF_W];
  assign unused_bits = ^{addr_q[BYTE_W-1:0], req_addr[BYTE_W-1:0], req_addr[ADDR_W-1 -: TAG_W]};

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_hit  = (state_q == ST_LOOK) && (|hit_w);
  assign look_miss = (state_q == ST_LOOK) && !(|hit_w);
  assign fill_last = (state_q == ST_FILL) && mem_ack && (cnt_q == BOFF_W'(BLOCK_WORDS - 1));
  assign rd_addr   = req_addr[BYTE_W +: RAM_AW];
  assign wr_addr   = {idx_f, cnt_q};

  assign mem_rd_en = (state_q == ST_FILL);
  assign mem_addr  = {tag_f, idx_f, cnt_q, {BYTE_W{1'b0}}};

  for (genvar w = 0; w < 2; w++) begin : g_way
    c2w_data_ram #(.DEPTH(RAM_DEPTH), .DW(WORD_W)) u_ram (
      .clk   (clk),
      .we    ((state_q == ST_FILL) && mem_ack && (vic_q == 1'(w))),
      .waddr (wr_addr),
      .wdata (mem_rdata),
      .re    (accept),
      .raddr (rd_addr),
      .rdata (rd_data[w])
    );
    assign hit_w[w] = valid_q[idx_f][w] && (tag_q[idx_f][w] == tag_f);
  end

  c2w_use_bits #(.SETS(SETS), .PERIOD(CLR_PERIOD)) u_use (
    .clk     (clk),
    .rst     (rst),
    .set_en  (look_hit || fill_last),
    .set_idx (idx_f),
    .set_way ((state_q == ST_LOOK) ? hit_w[1] : vic_q),
    .use_o   (use_w)
  );

  c2w_victim u_vic (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_q[idx_f]),
    .use_i   (use_w[idx_f]),
    .take_i  (look_miss),
    .way_o   (vic_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      cnt_q       <= '0;
      vic_q       <= 1'b0;
      fill_word_q <= '0;
      valid_q     <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_data   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (|hit_w) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= hit_w[1] ? rd_data[1] : rd_data[0];
            state_q    <= ST_IDLE;
          end else begin
            vic_q                 <= vic_w;
            cnt_q                 <= '0;
            valid_q[idx_f][vic_w] <= 1'b0;
            state_q               <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == boff_f) fill_word_q <= mem_rdata;
            if (fill_last) begin
              valid_q[idx_f][vic_q] <= 1'b1;
              resp_valid <= 1'b1;
              resp_hit   <= 1'b0;
              resp_data  <= (cnt_q == boff_f) ? mem_rdata : fill_word_q;
              state_q    <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_last) tag_q[idx_f][vic_q] <= tag_f;
  end

  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK) |-> !(hit_w[0] && hit_w[1]));                    // R2
  AST_HIT_FROM_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> ($past(state_q) == ST_LOOK));            // R2
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);                                          // R2
  AST_FILL_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !mem_ack) |=> $stable(mem_addr));                       // R3
  AST_EMPTY_WAY0_FIRST: assert property (@(posedge clk) disable iff (rst)
    (look_miss && !valid_q[idx_f][0]) |=> (vic_q == 1'b0));               // R5
  AST_EMPTY_WAY1_NEXT: assert property (@(posedge clk) disable iff (rst)
    (look_miss && valid_q[idx_f][0] && !valid_q[idx_f][1]) |=> (vic_q == 1'b1)); // R5
endmodule

// File: tb/test_c2w_cache.sv
module test_c2w_cache;
  localparam int PERIOD = 200;
  localparam int NVEC   = 8;
  // {address, expected hit}
  localparam logic [10:0] VEC [NVEC] = '{
    {10'b0100111000, 1'b0},   // R10 miss
    {10'b1100110100, 1'b0},   // R10 miss
    {10'b0100111100, 1'b1},   // R10 hit
    {10'b0110110000, 1'b0},   // R10 miss, R8 both set evicts way 0
    {10'b1100111000, 1'b1},   // R10 hit
    {10'b1100110111, 1'b1},   // R1 byte bits ignored
    {10'b0100111000, 1'b0},   // R8 way 0 evicted again (both use bits set)
    {10'b0000000000, 1'b0}    // R3 refill of set 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [9:0]  req_addr = '0;
  logic        req_ready, resp_valid, resp_hit, mem_rd_en;
  logic [31:0] resp_data;
  logic [9:0]  mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;
  int mem_k  = 0;
  logic [9:0] exp_base = '0;
  bit tog = 1'b0;

  always #10 clk = ~clk;

  c2w_cache #(.CLR_PERIOD(PERIOD)) i_c2w_cache (
    .clk, .rst, .req_valid, .req_addr, .req_ready, .resp_valid, .resp_hit,
    .resp_data, .mem_rd_en, .mem_addr, .mem_ack, .mem_rdata
  );

  function automatic logic [31:0] word_of(input logic [9:0] a);
    return 32'hC0DE_0000 | {22'd0, a[9:2], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  // memory model: acknowledges every other cycle, checks refill order
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      tog = 1'b0;
    end else begin
      tog = ~tog;
      mem_ack = mem_rd_en && tog;
      if (mem_ack) begin
        mem_rdata = word_of(mem_addr);
        chk(mem_addr == exp_base + 10'(mem_k * 4), "R3", "refill address",
            32'(mem_addr), 32'(exp_base + 10'(mem_k * 4)));
        mem_k++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // called at a negedge while the block is idle
  task automatic do_access(input logic [9:0] a, input bit exp_hit, input string rq);
    int n;
    exp_base = {a[9:4], 4'b0000};
    mem_k = 0;
    req_valid = 1'b1;
    req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(req_ready == 1'b0, "R4", "ready low while busy", 32'(req_ready), 32'd0);
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(resp_valid == 1'b1, rq, "response seen", 32'(resp_valid), 32'd1);
    chk(resp_hit == exp_hit, rq, "hit flag", 32'(resp_hit), 32'(exp_hit));
    chk(resp_data == word_of(a), rq, "data", resp_data, word_of(a));
    if (exp_hit) chk(n == 2, "R2", "hit latency", 32'(n), 32'd2);
    else if (mem_k != 4) chk(1'b0, "R3", "refill word count", 32'(mem_k), 32'd4);
    @(negedge clk);
  endtask

  task automatic wait_phase(input int ph);
    while (ecnt % PERIOD != ph) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R4 reset state
    chk(req_ready == 1'b1, "R4", "ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R4", "no response after reset", 32'(resp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R4", "no refill after reset", 32'(mem_rd_en), 32'd0);

    // vector table: reference sequence and layout (R1 R3 R8 R10)
    for (int i = 0; i < NVEC; i++) begin
      do_access(VEC[i][10:1], VEC[i][0], (i < 5) ? "R10" : "R1_R3_R8");
    end
    do_access(10'b0000001100, 1'b1, "R1");   // R1 other word of a loaded block

    // scenario B: empty-way preference and pointer ties (R5 R9)
    do_reset();
    do_access({4'h1, 2'b00, 4'h0}, 1'b0, "R5");
    do_access({4'h2, 2'b00, 4'h4}, 1'b0, "R5");
    do_access({4'h1, 2'b00, 4'h8}, 1'b1, "R5");   // R5 second fill took the empty way
    wait_phase(10);
    do_access({4'h3, 2'b00, 4'h0}, 1'b0, "R9");   // tie, pointer 0 evicts way 0
    do_access({4'h1, 2'b00, 4'h0}, 1'b0, "R9");   // R9 way 0 block was the one evicted
    wait_phase(10);
    do_access({4'h4, 2'b00, 4'h0}, 1'b0, "R9");   // tie, pointer now 1
    do_access({4'h3, 2'b00, 4'hC}, 1'b1, "R9");   // R9 way 0 kept after toggle

    // scenario C: clear on the same edge as a hit (R6 R7)
    do_reset();
    do_access({4'h1, 2'b01, 4'h0}, 1'b0, "R7");
    do_access({4'h2, 2'b01, 4'h0}, 1'b0, "R7");
    wait_phase(PERIOD - 2);
    do_access({4'h1, 2'b01, 4'h4}, 1'b1, "R7");   // lookup edge coincides with clear
    do_access({4'h3, 2'b01, 4'h0}, 1'b0, "R7");   // only way 1 use bit clear
    do_access({4'h1, 2'b01, 4'h8}, 1'b1, "R7");   // R7 hit block survived
    do_access({4'h2, 2'b01, 4'h0}, 1'b0, "R6");   // R6 cleared block was evicted

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule